// File: doc/BRIEF.md
# Filtered Event Performance Counter

This block holds two 40-bit performance counters. Each counter has its own 32-bit select register. Every cycle, a vector of small per-event counts arrives, one 2-bit count (0 to 3) for each event line. A privilege level, a cache line state and a self-generated flag for bus traffic arrive alongside the counts. The select register picks one event line by its code. The event is then narrowed by a unit mask and a privilege filter. It then passes through a per-cycle threshold test, which can be inverted, and an optional rising-edge detector before it reaches the counter.

A simple single-cycle register port handles the rest. It writes the select registers and writes (loads or clears) the counters. A combinational read port returns any select register or counter. The two counters are not symmetric: one event code may count only on counter 0, and another only on counter 1.

Top module: `perfctr_top`

## Requirements
- R1: After synchronous reset, both select registers and both counters read zero.
- R2: Addresses are decoded as follows. A write to address 0 or 1 stores `wr_data` in select register 0 or 1, and the register reads back unchanged. A write to address 2 or 3 loads counter 0 or 1 with `wr_data` shifted left by 8 (the low 8 bits become zero). A write of zero therefore clears the counter. Reads use the same address map.
- R3: A counter never advances unless its enable bit (bit 22) is set and its event code (bits 7:0) is nonzero.
- R4: With a threshold (bits 31:24) of zero, the counter adds the full 2-bit count of event line `code` each cycle. Event line k is `evt_cnt[2k+1:2k]`.
- R5: With a nonzero threshold, the counter adds 1 in each cycle whose event count is at least the threshold, and nothing otherwise.
- R6: With the invert bit (bit 23) set and a nonzero threshold, the counter adds 1 in each cycle whose count is below the threshold.
- R7: With the edge bit (bit 18) set, the counter adds 1 only on a cycle where the qualified condition is true and was false the cycle before. The condition is a count above zero when the threshold is zero, otherwise the threshold test. Writing the select register clears this history.
- R8: Privilege 3 (`priv` = 3) counts only if the user bit (bit 16) is set. Privilege levels 0 to 2 count only if the kernel bit (bit 17) is set.
- R9: Codes 8 to 11 are cache-state events. They count only when the mask bit for the current `line_state` is set. The mask bit is bit 8 for I (state 0), bit 9 for S (state 1), bit 10 for E (state 2) and bit 11 for M (state 3).
- R10: Codes 12 to 15 are bus events. When the any bit (bit 13) is set, every cycle counts. When it is clear, a cycle counts only while `bus_self` is high.
- R11: Code 4 counts only on counter 0, and code 5 counts only on counter 1. A code of 16 or above counts on neither counter.
- R12: Each counter wraps silently modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0/1 select, 2/3 counter |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 40 | Read data, select values zero-extended |
| evt_cnt | input | 32 | Sixteen 2-bit per-cycle event counts |
| priv | input | 2 | Current privilege level, 3 = user |
| line_state | input | 2 | Cache line state: 0 I, 1 S, 2 E, 3 M |
| bus_self | input | 1 | Bus event this cycle is self-generated |

## Verification
The hardest condition to reach from the ports is the wrap of a 40-bit counter. Counting up to it would take far too many cycles. The stimulus instead loads the counter near the top through the shifted counter write, then drives count-3 events until it rolls over. A second hard case is the clearing of edge history by a select write while the condition stays high. To reach it, the bench holds an event active across a rewrite of an identical select value and expects exactly one extra increment.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;

    localparam int EVT_N_DEF  = 16;
    localparam int EVT_W_DEF  = 2;
    localparam int SEL_W      = 32;

    localparam logic [7:0] CODE_CTR0_ONLY = 8'd4;
    localparam logic [7:0] CODE_CTR1_ONLY = 8'd5;
    localparam logic [7:0] CODE_MESI_LO   = 8'd8;
    localparam logic [7:0] CODE_MESI_HI   = 8'd11;
    localparam logic [7:0] CODE_BUS_LO    = 8'd12;
    localparam logic [7:0] CODE_BUS_HI    = 8'd15;
    localparam int         UM_ANY_BIT     = 5;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_state_e;

    typedef struct packed {
        logic [7:0] thr;
        logic       inv;
        logic       en;
        logic [2:0] rsv;
        logic       edg;
        logic       krn;
        logic       usr;
        logic [7:0] umask;
        logic [7:0] code;
    } sel_t;

    function automatic logic code_allowed(input logic [7:0] code, input int idx);
        if (code == CODE_CTR0_ONLY) return idx == 0;
        if (code == CODE_CTR1_ONLY) return idx == 1;
        return 1'b1;
    endfunction

    function automatic logic is_mesi(input logic [7:0] code);
        return code >= CODE_MESI_LO && code <= CODE_MESI_HI;
    endfunction

    function automatic logic is_bus(input logic [7:0] code);
        return code >= CODE_BUS_LO && code <= CODE_BUS_HI;
    endfunction

endpackage

// File: rtl/perfctr_qual.sv
module perfctr_qual
    import perfctr_pkg::*;
#(
    parameter int CTR_IDX = 0,
    parameter int EVT_N   = EVT_N_DEF,
    parameter int EVT_W   = EVT_W_DEF
) (
    input  sel_t                   sel,
    input  logic [EVT_N*EVT_W-1:0] evt_cnt,
    input  logic [1:0]             priv,
    input  logic [1:0]             line_state,
    input  logic                   bus_self,
    output logic [EVT_W-1:0]       q,
    output logic                   gate
);
    localparam int CODE_LIM = EVT_N;

    logic             code_ok;
    logic             priv_ok;
    logic             um_ok;
    logic [EVT_W-1:0] raw;

    always_comb begin
        code_ok = (sel.code != 8'd0) && (int'(sel.code) < CODE_LIM) &&
                  code_allowed(sel.code, CTR_IDX);
        raw = '0;
        for (int k = 0; k < EVT_N; k++) begin
            if (int'(sel.code) == k) raw = evt_cnt[k*EVT_W +: EVT_W];
        end
        priv_ok = (priv == 2'd3) ? sel.usr : sel.krn;
        if (is_mesi(sel.code))
            um_ok = sel.umask[line_state];
        else if (is_bus(sel.code))
            um_ok = sel.umask[UM_ANY_BIT] | bus_self;
        else
            um_ok = 1'b1;
        gate = sel.en && code_ok && priv_ok && um_ok;
        q    = gate ? raw : '0;
    end

endmodule

// File: rtl/perfctr_unit.sv
module perfctr_unit
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_W = EVT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_t             sel,
    input  logic [EVT_W-1:0] q,
    input  logic             gate,
    input  logic             sel_wr,
    input  logic             ctr_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    localparam int MAX_STEP = (1 << EVT_W) - 1;

    logic             cond;
    logic             prev;
    logic [CNT_W-1:0] inc;

    always_comb begin
        if (!gate)
            cond = 1'b0;
        else if (sel.thr == 8'd0)
            cond = (q != '0);
        else if (sel.inv)
            cond = (8'(q) < sel.thr);
        else
            cond = (8'(q) >= sel.thr);

        if (sel.edg)
            inc = CNT_W'(cond && !prev);
        else if (sel.thr == 8'd0)
            inc = CNT_W'(q);
        else
            inc = CNT_W'(cond);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            prev <= 1'b0;
        end else begin
            prev <= sel_wr ? 1'b0 : cond;
            cnt  <= ctr_wr ? load_val : cnt + inc;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        ctr_wr |=> cnt == $past(load_val));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!gate && !ctr_wr) |=> cnt == $past(cnt));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        !ctr_wr |=> CNT_W'(cnt - $past(cnt)) <= CNT_W'(MAX_STEP));

    p_unit_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctr_wr && sel.thr != 8'd0) |=> CNT_W'(cnt - $past(cnt)) <= CNT_W'(1));

    p_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctr_wr && sel.edg) |=> CNT_W'(cnt - $past(cnt)) <= CNT_W'(1));

endmodule

// File: rtl/perfctr_top.sv
module perfctr_top
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_N = EVT_N_DEF,
    parameter int EVT_W = EVT_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [1:0]             rd_addr,
    output logic [CNT_W-1:0]       rd_data,
    input  logic [EVT_N*EVT_W-1:0] evt_cnt,
    input  logic [1:0]             priv,
    input  logic [1:0]             line_state,
    input  logic                   bus_self
);
    localparam int NUM_CTR = 2;
    localparam int LOW_W   = (CNT_W > SEL_W) ? CNT_W - SEL_W : 0;

    sel_t             sel_q [NUM_CTR];
    logic [CNT_W-1:0] cnt   [NUM_CTR];
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(wr_data) << LOW_W;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic             sel_wr;
        logic             ctr_wr;
        logic [EVT_W-1:0] q;
        logic             gate;

        assign sel_wr = wr_en && (wr_addr == 2'(i));
        assign ctr_wr = wr_en && (wr_addr == 2'(i + 2));

        always_ff @(posedge clk) begin
            if (rst)         sel_q[i] <= '0;
            else if (sel_wr) sel_q[i] <= sel_t'(wr_data);
        end

        perfctr_qual #(.CTR_IDX(i), .EVT_N(EVT_N), .EVT_W(EVT_W)) u_qual (
            .sel(sel_q[i]), .evt_cnt(evt_cnt), .priv(priv),
            .line_state(line_state), .bus_self(bus_self),
            .q(q), .gate(gate)
        );

        perfctr_unit #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_unit (
            .clk(clk), .rst(rst), .sel(sel_q[i]), .q(q), .gate(gate),
            .sel_wr(sel_wr), .ctr_wr(ctr_wr), .load_val(load_val),
            .cnt(cnt[i])
        );
    end

    always_comb begin
        case (rd_addr)
            2'd0:    rd_data = CNT_W'(sel_q[0]);
            2'd1:    rd_data = CNT_W'(sel_q[1]);
            2'd2:    rd_data = cnt[0];
            default: rd_data = cnt[1];
        endcase
    end

    p_selrd_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> CNT_W'(sel_q[0]) == CNT_W'($past(wr_data)));

endmodule

// File: tb/sim_perfctr_top.sv
module sim_perfctr_top;
    localparam int CLK_P = 10;
    localparam int CW    = 40;

    logic          clk = 0;
    logic          rst = 1;
    logic          wr_en = 0;
    logic [1:0]    wr_addr = 0;
    logic [31:0]   wr_data = 0;
    logic [1:0]    rd_addr = 0;
    logic [CW-1:0] rd_data;
    logic [31:0]   evt_cnt = 0;
    logic [1:0]    priv = 0;
    logic [1:0]    line_state = 0;
    logic          bus_self = 0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    perfctr_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_cnt(evt_cnt), .priv(priv), .line_state(line_state),
        .bus_self(bus_self)
    );

    function automatic logic [31:0] mk_sel(input logic [7:0] code, input logic [7:0] um,
                                           input bit usr, input bit krn, input bit edg,
                                           input bit en, input bit inv, input logic [7:0] thr);
        return {thr, inv, en, 3'b000, edg, krn, usr, um, code};
    endfunction

    task automatic check(input string req, input logic [1:0] addr, input logic [CW-1:0] exp);
        rd_addr = addr;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic setev(input int k, input logic [1:0] v);
        evt_cnt[k*2 +: 2] = v;
    endtask

    task automatic drive(input int k, input logic [1:0] v);
        setev(k, v);
        @(negedge clk);
    endtask

    task automatic arm0(input logic [31:0] s);
        evt_cnt = 0;
        wr(2'd0, s);
        wr(2'd2, 32'd0);
    endtask

    task automatic t_reset;
        check("R1", 2'd0, '0);
        check("R1", 2'd1, '0);
        check("R1", 2'd2, '0);
        check("R1", 2'd3, '0);
    endtask

    task automatic t_regs;
        wr(2'd1, 32'hA5C7_1234);
        check("R2", 2'd1, 40'h00A5C71234);
        wr(2'd2, 32'h0000_0001);
        check("R2", 2'd2, 40'h0000000100);
        wr(2'd2, 32'd0);
        check("R2", 2'd2, '0);
        wr(2'd1, 32'd0);
    endtask

    task automatic t_thr0;
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        setev(2, 2'd3);
        repeat (4) drive(1, 2'd3);
        repeat (2) drive(1, 2'd2);
        evt_cnt = 0;
        check("R4", 2'd2, 40'd16);
    endtask

    task automatic t_enable;
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 0, 0, 0, 8'd0));
        repeat (3) drive(1, 2'd3);
        evt_cnt = 0;
        check("R3 enable clear", 2'd2, 40'd0);
        arm0(mk_sel(8'd0, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        setev(0, 2'd3);
        repeat (3) @(negedge clk);
        evt_cnt = 0;
        check("R3 code zero", 2'd2, 40'd0);
    endtask

    task automatic t_thr;
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 0, 1, 0, 8'd2));
        drive(1, 2'd1); drive(1, 2'd2); drive(1, 2'd3); drive(1, 2'd0); drive(1, 2'd2);
        evt_cnt = 0;
        check("R5", 2'd2, 40'd3);
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 0, 1, 1, 8'd2));
        drive(1, 2'd1); drive(1, 2'd2); drive(1, 2'd3); drive(1, 2'd0); drive(1, 2'd2);
        evt_cnt = 0;
        check("R6", 2'd2, 40'd2);
    endtask

    task automatic t_edge;
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 1, 1, 0, 8'd0));
        drive(1, 2'd1); drive(1, 2'd1); drive(1, 2'd0); drive(1, 2'd3);
        drive(1, 2'd3); drive(1, 2'd0); drive(1, 2'd2);
        evt_cnt = 0;
        check("R7 rises", 2'd2, 40'd3);
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 1, 1, 0, 8'd0));
        setev(1, 2'd1);
        repeat (3) @(negedge clk);
        wr(2'd0, mk_sel(8'd1, 8'd0, 1, 1, 1, 1, 0, 8'd0));
        repeat (2) @(negedge clk);
        evt_cnt = 0;
        check("R7 history cleared", 2'd2, 40'd2);
    endtask

    task automatic t_priv;
        arm0(mk_sel(8'd1, 8'd0, 1, 0, 0, 1, 0, 8'd0));
        priv = 2'd3; drive(1, 2'd1);
        priv = 2'd1; drive(1, 2'd1);
        priv = 2'd0; drive(1, 2'd1);
        evt_cnt = 0;
        check("R8 user only", 2'd2, 40'd1);
        arm0(mk_sel(8'd1, 8'd0, 0, 1, 0, 1, 0, 8'd0));
        priv = 2'd0; drive(1, 2'd1);
        priv = 2'd1; drive(1, 2'd1);
        priv = 2'd2; drive(1, 2'd1);
        priv = 2'd3; drive(1, 2'd1);
        evt_cnt = 0; priv = 2'd0;
        check("R8 kernel only", 2'd2, 40'd3);
    endtask

    task automatic t_mesi;
        arm0(mk_sel(8'd8, 8'h09, 1, 1, 0, 1, 0, 8'd0));
        for (int s = 0; s < 4; s++) begin
            line_state = 2'(s);
            drive(8, 2'd2);
        end
        evt_cnt = 0; line_state = 0;
        check("R9 mask M and I", 2'd2, 40'd4);
    endtask

    task automatic t_sa;
        arm0(mk_sel(8'd12, 8'h00, 1, 1, 0, 1, 0, 8'd0));
        bus_self = 1; drive(12, 2'd1);
        bus_self = 0; drive(12, 2'd1);
        bus_self = 1; drive(12, 2'd1);
        evt_cnt = 0;
        check("R10 self only", 2'd2, 40'd2);
        arm0(mk_sel(8'd12, 8'h20, 1, 1, 0, 1, 0, 8'd0));
        bus_self = 1; drive(12, 2'd1);
        bus_self = 0; drive(12, 2'd1);
        bus_self = 1; drive(12, 2'd1);
        evt_cnt = 0; bus_self = 0;
        check("R10 any", 2'd2, 40'd3);
    endtask

    task automatic t_restrict;
        evt_cnt = 0;
        wr(2'd0, mk_sel(8'd4, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        wr(2'd1, mk_sel(8'd5, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        wr(2'd2, 32'd0); wr(2'd3, 32'd0);
        setev(4, 2'd1); setev(5, 2'd1);
        repeat (3) @(negedge clk);
        evt_cnt = 0;
        check("R11 code4 on ctr0", 2'd2, 40'd3);
        check("R11 code5 on ctr1", 2'd3, 40'd3);
        wr(2'd0, mk_sel(8'd5, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        wr(2'd1, mk_sel(8'd4, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        wr(2'd2, 32'd0); wr(2'd3, 32'd0);
        setev(4, 2'd1); setev(5, 2'd1);
        repeat (3) @(negedge clk);
        evt_cnt = 0;
        check("R11 code5 on ctr0", 2'd2, 40'd0);
        check("R11 code4 on ctr1", 2'd3, 40'd0);
        wr(2'd1, 32'd0);
        arm0(mk_sel(8'd16, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        evt_cnt = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        evt_cnt = 0;
        check("R11 code out of range", 2'd2, 40'd0);
    endtask

    task automatic t_wrap;
        arm0(mk_sel(8'd1, 8'd0, 1, 1, 0, 1, 0, 8'd0));
        wr(2'd2, 32'hFFFF_FFFF);
        check("R12 preload", 2'd2, 40'hFFFFFFFF00);
        setev(1, 2'd3);
        repeat (86) @(negedge clk);
        evt_cnt = 0;
        check("R12 wrap", 2'd2, 40'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_thr0;
        t_enable;
        t_thr;
        t_edge;
        t_priv;
        t_mesi;
        t_sa;
        t_restrict;
        t_wrap;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule